// File: doc/BRIEF.md
# Duplex Grid PWM Dimmer

This block times the drive of a two-grid, 23-segment vacuum fluorescent display. A free-running frame of 2048 clocks is split into two 1024-clock halves. The first grid owns the first half and the second grid owns the second half. Within each half, the grid enable is high for a number of clocks set by a 10-bit dimming value. The segment enables open a few clocks before the grid and close with it. During each half, the segment enables carry the 23 display bits that belong to the active grid.

Two override modes reuse the same timing. Default mode shows only the two lowest segments, at the dimming value held from before. Test mode (active-low test input) runs at maximum duty and blinks all segments together. The dimming value and both mode inputs are sampled once per frame at the frame boundary, so no grid pulse is ever cut short or stretched.

Top module: `vfd_duplex_dimmer`

## Requirements
- R1: A frame is 2048 clocks long. `grid_en[0]` pulses once in the first 1024-clock half and `grid_en[1]` once in the second half. The two grid rising edges are exactly 1024 clocks apart, and the grids are never on together.
- R2: For a sampled dimming value d in 1..1015, each grid pulse lasts exactly d clocks.
- R3: A sampled dimming value of 1016 or more gives a grid pulse of exactly 1016 clocks.
- R4: A sampled dimming value of 0 keeps every grid and segment enable low for the whole frame.
- R5: A segment pulse starts exactly 3 clocks before its grid pulse and ends on the same clock, so it lasts d+3 clocks (1019 at maximum).
- R6: While `grid_en[0]` is high, `seg_en[i]` follows `disp_word[i]`. While `grid_en[1]` is high, `seg_en[i]` follows `disp_word[23+i]`.
- R7: The dimming value, `dflt_mode` and `test_n` are sampled only on the last clock of a frame. A change in mid-frame never produces a pulse length other than the old or the new one. Every output stays low during the first frame after reset.
- R8: With `dflt_mode` high and test inactive, only `seg_en[1:0]` are driven within the segment window, and the sampled dimming value sets the grid length.
- R9: With `test_n` low, grids run at the maximum length of 1016 clocks. All 23 segments are on together for the first 2 frames (`BLINK_FRAMES`), off for the next 2, and so on, whatever the display word. Test mode overrides default mode.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one clock per time slot |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_word | input | 46 | Display bits: [22:0] for grid 0, [45:23] for grid 1 |
| dim_val | input | 10 | Dimming value in clocks of grid on-time |
| dflt_mode | input | 1 | Fallback mode request: show only the two lowest segments |
| test_n | input | 1 | Active-low self-test request |
| grid_en | output | 2 | Grid enables, one per frame half |
| seg_en | output | 23 | Segment enables |

## Verification
The dimming path is tried with the values 1, 300, 1016 and 1023, and separately with 0. The first two separate exact tracking from an off-by-one. The upper pair separates the clamp from a wrap or pass-through. Zero separates a true blackout from a residual 3-clock segment lead. Two unlike display words, one alternating bits and one with a walking pattern across the two halves, separate a correct half-to-slice mapping from swapped or shifted slices. A dimming change placed inside a running grid pulse shows whether sampling waits for the frame boundary. Default mode combined with test mode shows which override has priority.

// File: rtl/vfd_dim_pkg.sv
package vfd_dim_pkg;

   // Source of the segment pattern for the current frame
   typedef enum logic [1:0] {
      SRC_DISPLAY   = 2'd0,
      SRC_DEFAULT   = 2'd1,
      SRC_BLINK_ON  = 2'd2,
      SRC_BLINK_OFF = 2'd3
   } seg_src_e;

endpackage

// File: rtl/vfd_frame_timer.sv
module vfd_frame_timer #(
   parameter int HALF_W = 10,
   parameter int GRID_N = 2,
   localparam int GSEL_W = (GRID_N > 1) ? $clog2(GRID_N) : 1,
   localparam int FRAME_W = HALF_W + GSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [HALF_W-1:0] half_pos,
   output logic [GSEL_W-1:0] grid_idx,
   output logic              frame_end
);

   generate
      if ((1 << GSEL_W) != GRID_N) begin : g_bad_grid_n
         $error("GRID_N must be a power of two of at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= pos_q + 1'b1;
   end

   assign half_pos  = pos_q[HALF_W-1:0];
   assign grid_idx  = pos_q[FRAME_W-1:HALF_W];
   assign frame_end = &pos_q;

endmodule

// File: rtl/vfd_frame_cfg.sv
module vfd_frame_cfg
   import vfd_dim_pkg::*;
#(
   parameter int DIM_W        = 10,
   parameter int DUTY_MAX     = 1016,
   parameter int BLINK_FRAMES = 256,
   localparam int CNT_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end,
   input  logic [DIM_W-1:0] dim_in,
   input  logic             dflt_in,
   input  logic             test_n_in,
   output logic [DIM_W-1:0] dim_q,
   output seg_src_e         src
);

   generate
      if (BLINK_FRAMES < 1) begin : g_bad_blink
         $error("BLINK_FRAMES must be at least 1");
      end
   endgenerate

   localparam logic [DIM_W-1:0] DMAX = DIM_W'(DUTY_MAX);

   logic [DIM_W-1:0] dim_lim;
   logic [CNT_W-1:0] cnt_q;
   logic             test_q;
   logic             dflt_q;
   logic             phase_q;

   // Clamp variant chosen by whether the ceiling can be exceeded at all
   generate
      if (DUTY_MAX >= (1 << DIM_W) - 1) begin : g_no_clamp
         assign dim_lim = dim_in;
      end else begin : g_clamp
         assign dim_lim = (dim_in > DMAX) ? DMAX : dim_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dim_q   <= '0;
         cnt_q   <= '0;
         test_q  <= 1'b0;
         dflt_q  <= 1'b0;
         phase_q <= 1'b1;
      end else if (frame_end) begin
         test_q <= !test_n_in;
         dflt_q <= dflt_in;
         if (!test_n_in) begin
            dim_q <= DMAX;
            if (test_q) begin
               if (cnt_q == CNT_W'(BLINK_FRAMES - 1)) begin
                  cnt_q   <= '0;
                  phase_q <= !phase_q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q   <= '0;
               phase_q <= 1'b1;
            end
         end else begin
            dim_q   <= dim_lim;
            cnt_q   <= '0;
            phase_q <= 1'b1;
         end
      end
   end

   always_comb begin
      if (test_q)      src = phase_q ? SRC_BLINK_ON : SRC_BLINK_OFF;
      else if (dflt_q) src = SRC_DEFAULT;
      else             src = SRC_DISPLAY;
   end

endmodule

// File: rtl/vfd_window.sv
module vfd_window #(
   parameter int HALF_W   = 10,
   parameter int DIM_W    = 10,
   parameter int DUTY_MAX = 1016,
   parameter int BLANK    = 5,
   parameter int LEAD     = 3
) (
   input  logic [HALF_W-1:0] half_pos,
   input  logic [DIM_W-1:0]  dim,
   output logic              grid_win,
   output logic              seg_win
);

   localparam int SUM_W      = HALF_W + 1;
   localparam int GRID_START = BLANK + LEAD;

   generate
      if (DIM_W > HALF_W) begin : g_bad_dim_w
         $error("DIM_W must not exceed HALF_W");
      end
      if (GRID_START + DUTY_MAX > (1 << HALF_W)) begin : g_bad_fit
         $error("blanking, lead and maximum duty do not fit in one half");
      end
   endgenerate

   logic [SUM_W-1:0] pos_x;
   logic [SUM_W-1:0] stop_x;
   logic             dim_nz;

   assign pos_x  = SUM_W'(half_pos);
   assign stop_x = SUM_W'(GRID_START) + SUM_W'(dim);
   assign dim_nz = |dim;

   assign grid_win = dim_nz && (pos_x >= SUM_W'(GRID_START)) && (pos_x < stop_x);
   assign seg_win  = dim_nz && (pos_x >= SUM_W'(BLANK)) && (pos_x < stop_x);

endmodule

// File: rtl/vfd_duplex_dimmer.sv
module vfd_duplex_dimmer
   import vfd_dim_pkg::*;
#(
   parameter int                      SEG_N        = 23,
   parameter int                      GRID_N       = 2,
   parameter int                      HALF_W       = 10,
   parameter int                      DIM_W        = 10,
   parameter int                      DUTY_MAX     = 1016,
   parameter int                      BLANK        = 5,
   parameter int                      LEAD         = 3,
   parameter int                      BLINK_FRAMES = 256,
   parameter logic [SEG_N-1:0]        DFLT_MASK    = SEG_N'(3),
   localparam int                     WORD_W       = SEG_N * GRID_N,
   localparam int                     GSEL_W       = (GRID_N > 1) ? $clog2(GRID_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] disp_word,
   input  logic [DIM_W-1:0]  dim_val,
   input  logic              dflt_mode,
   input  logic              test_n,
   output logic [GRID_N-1:0] grid_en,
   output logic [SEG_N-1:0]  seg_en
);

   logic [HALF_W-1:0] half_pos;
   logic [GSEL_W-1:0] grid_idx;
   logic              frame_end;
   logic [DIM_W-1:0]  cfg_dim;
   seg_src_e          cfg_src;
   logic              grid_win;
   logic              seg_win;
   logic [GRID_N-1:0] grid_c;
   logic [SEG_N-1:0]  seg_pat;
   logic [SEG_N-1:0]  slice [GRID_N];

   vfd_frame_timer #(.HALF_W(HALF_W), .GRID_N(GRID_N)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_pos  (half_pos),
      .grid_idx  (grid_idx),
      .frame_end (frame_end)
   );

   vfd_frame_cfg #(
      .DIM_W(DIM_W), .DUTY_MAX(DUTY_MAX), .BLINK_FRAMES(BLINK_FRAMES)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .dim_in    (dim_val),
      .dflt_in   (dflt_mode),
      .test_n_in (test_n),
      .dim_q     (cfg_dim),
      .src       (cfg_src)
   );

   vfd_window #(
      .HALF_W(HALF_W), .DIM_W(DIM_W), .DUTY_MAX(DUTY_MAX),
      .BLANK(BLANK), .LEAD(LEAD)
   ) u_win (
      .half_pos (half_pos),
      .dim      (cfg_dim),
      .grid_win (grid_win),
      .seg_win  (seg_win)
   );

   // One display slice and one grid select per frame half
   generate
      for (genvar g = 0; g < GRID_N; g++) begin : g_grid
         assign slice[g]  = disp_word[g*SEG_N +: SEG_N];
         assign grid_c[g] = grid_win && (grid_idx == GSEL_W'(g));
      end
   endgenerate

   always_comb begin
      unique case (cfg_src)
         SRC_DISPLAY:  seg_pat = slice[grid_idx];
         SRC_DEFAULT:  seg_pat = DFLT_MASK;
         SRC_BLINK_ON: seg_pat = '1;
         default:      seg_pat = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grid_en <= '0;
         seg_en  <= '0;
      end else begin
         grid_en <= grid_c;
         seg_en  <= seg_win ? seg_pat : '0;
      end
   end

endmodule

// File: rtl/vfd_duplex_dimmer_chk.sv
module vfd_duplex_dimmer_chk
   import vfd_dim_pkg::*;
#(
   parameter int               SEG_N     = 23,
   parameter int               GRID_N    = 2,
   parameter int               DIM_W     = 10,
   parameter int               DUTY_MAX  = 1016,
   parameter logic [SEG_N-1:0] DFLT_MASK = SEG_N'(3)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [GRID_N-1:0] grid_en,
   input logic [SEG_N-1:0]  seg_en,
   input logic [DIM_W-1:0]  cfg_dim,
   input seg_src_e          cfg_src,
   input logic              frame_end
);

   // R1: at most one grid is on at any time
   assert_grid_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grid_en));

   // R3: the sampled dimming value never exceeds the ceiling
   assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dim <= DIM_W'(DUTY_MAX));

   // R4: a zero dimming value gives dark outputs on the next clock
   assert_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dim == '0) |=> (grid_en == '0 && seg_en == '0));

   // R7: the sampled dimming value moves only after a frame end
   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(cfg_dim));

   // R8: default mode drives no segment outside the mask
   assert_dflt_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src == SRC_DEFAULT) |=> ((seg_en & ~DFLT_MASK) == '0));

   // R9: test mode drives all segments alike
   assert_blink_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src == SRC_BLINK_ON || cfg_src == SRC_BLINK_OFF) |=> (seg_en == '0 || &seg_en));

   // R9: the off phase of the blink drives no segment
   assert_blink_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src == SRC_BLINK_OFF) |=> (seg_en == '0));

endmodule

bind vfd_duplex_dimmer vfd_duplex_dimmer_chk #(
   .SEG_N(SEG_N), .GRID_N(GRID_N), .DIM_W(DIM_W),
   .DUTY_MAX(DUTY_MAX), .DFLT_MASK(DFLT_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grid_en   (grid_en),
   .seg_en    (seg_en),
   .cfg_dim   (cfg_dim),
   .cfg_src   (cfg_src),
   .frame_end (frame_end)
);

// File: tb/tb_vfd_duplex_dimmer.sv
`timescale 1ns/1ps
module tb_vfd_duplex_dimmer;

   localparam int FRAME = 2048;
   localparam int HALF  = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [45:0] disp_word = '0;
   logic [9:0]  dim_val = '0;
   logic        dflt_mode = 1'b0;
   logic        test_n = 1'b1;
   logic [1:0]  grid_en;
   logic [22:0] seg_en;

   int n_chk = 0;
   int n_fail = 0;

   vfd_duplex_dimmer #(.BLINK_FRAMES(2)) dut (
      .clk(clk), .rst_n(rst_n), .disp_word(disp_word), .dim_val(dim_val),
      .dflt_mode(dflt_mode), .test_n(test_n), .grid_en(grid_en), .seg_en(seg_en)
   );

   always #5 clk = ~clk;

   // Monitor state, written only by the monitor
   int          t = 0;
   int          run [2] = '{0, 0};
   int          len [2] = '{0, 0};
   int          pulses [2] = '{0, 0};
   int          rise_t [2] = '{0, 0};
   logic [22:0] snap [2];
   logic [22:0] hist [16];
   int          seg0_run = 0;
   int          seg0_len = 0;
   int          seg0_rise_t = 0;
   int          lead = -1;
   int          hi_cnt = 0;
   int          overlap_cnt = 0;
   int          bad_len = 0;
   bit          len_chk_en = 1'b0;
   int          alw_a = 0;
   int          alw_b = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         t = t + 1;
         if (grid_en != 0 || seg_en != 0) hi_cnt = hi_cnt + 1;
         if (grid_en == 2'b11) overlap_cnt = overlap_cnt + 1;
         if (seg_en[0]) begin
            if (seg0_run == 0) seg0_rise_t = t;
            seg0_run = seg0_run + 1;
         end else if (seg0_run != 0) begin
            seg0_len = seg0_run;
            seg0_run = 0;
         end
         for (int g = 0; g < 2; g++) begin
            if (grid_en[g]) begin
               if (run[g] == 0) begin
                  rise_t[g] = t;
                  if (seg_en[0]) lead = t - seg0_rise_t;
               end
               run[g] = run[g] + 1;
               if (run[g] == 50) begin
                  snap[g] = seg_en;
                  if (g == 0) hist[pulses[0] % 16] = seg_en;
               end
            end else if (run[g] != 0) begin
               len[g] = run[g];
               if (len_chk_en && run[g] != alw_a && run[g] != alw_b)
                  bad_len = bad_len + 1;
               pulses[g] = pulses[g] + 1;
               run[g] = 0;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_frames(input int n);
      repeat (n * FRAME) @(posedge clk);
      @(negedge clk); #1;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      dim_val = 10'd300;
      disp_word = '1;
      repeat (5) @(posedge clk);
      @(negedge clk); #1;
      chk(grid_en == 0, "R10 grid_en in reset", grid_en, 0);
      chk(seg_en == 0, "R10 seg_en in reset", seg_en, 0);
      rst_n = 1'b1;
      begin
         int base;
         base = hi_cnt;
         repeat (2000) @(posedge clk);
         @(negedge clk); #1;
         chk(hi_cnt == base, "R7 first frame dark", hi_cnt - base, 0);
      end
   endtask

   task automatic t_frame;
      int base_ov;
      int diff;
      base_ov = overlap_cnt;
      wait_frames(3);
      diff = (rise_t[1] - rise_t[0] + 2 * FRAME) % FRAME;
      chk(diff == HALF, "R1 grid spacing", diff, HALF);
      chk(overlap_cnt == base_ov, "R1 grid overlap", overlap_cnt - base_ov, 0);
      chk(pulses[0] - pulses[1] inside {0, 1}, "R1 one pulse each", pulses[0] - pulses[1], 0);
   endtask

   task automatic t_dim(input int val, input int exp, input string req);
      dim_val = 10'(val);
      disp_word = '1;
      wait_frames(3);
      chk(len[0] == exp, req, len[0], exp);
      chk(len[1] == exp, req, len[1], exp);
      chk(seg0_len == exp + 3, "R5 segment length", seg0_len, exp + 3);
      chk(lead == 3, "R5 segment lead", lead, 3);
   endtask

   task automatic t_dark;
      int base;
      dim_val = '0;
      wait_frames(2);
      base = hi_cnt;
      wait_frames(1);
      chk(hi_cnt == base, "R4 zero dimming dark", hi_cnt - base, 0);
   endtask

   task automatic t_content(input logic [45:0] w);
      dim_val = 10'd300;
      disp_word = w;
      wait_frames(3);
      chk(snap[0] == w[22:0], "R6 grid0 segments", snap[0], w[22:0]);
      chk(snap[1] == w[45:23], "R6 grid1 segments", snap[1], w[45:23]);
   endtask

   task automatic t_boundary;
      int base;
      dim_val = 10'd500;
      wait_frames(3);
      alw_a = 500;
      alw_b = 200;
      base = bad_len;
      len_chk_en = 1'b1;
      @(posedge grid_en[0]);
      repeat (100) @(posedge clk);
      dim_val = 10'd200;
      @(negedge grid_en[1]);
      @(negedge clk); #1;
      chk(len[0] == 500, "R7 grid0 in change frame", len[0], 500);
      chk(len[1] == 500, "R7 grid1 in change frame", len[1], 500);
      wait_frames(3);
      chk(len[0] == 200, "R7 new value applied", len[0], 200);
      chk(bad_len == base, "R7 no partial pulse", bad_len - base, 0);
      len_chk_en = 1'b0;
   endtask

   task automatic t_default;
      dim_val = 10'd300;
      disp_word = 46'h1555_5555_5554;
      dflt_mode = 1'b1;
      wait_frames(3);
      chk(snap[0] == 23'h3, "R8 grid0 default pattern", snap[0], 3);
      chk(snap[1] == 23'h3, "R8 grid1 default pattern", snap[1], 3);
      chk(len[0] == 300, "R8 retained dimming", len[0], 300);
   endtask

   task automatic t_test;
      int p;
      dim_val = 10'd100;
      disp_word = '0;
      dflt_mode = 1'b1;
      @(negedge grid_en[0]);
      @(negedge clk); #1;
      p = pulses[0];
      test_n = 1'b0;
      wait_frames(6);
      chk(len[0] == 1016, "R9 maximum duty", len[0], 1016);
      chk(hist[p % 16] == '1, "R9 blink frame 1 on", hist[p % 16], 23'h7FFFFF);
      chk(hist[(p + 1) % 16] == '1, "R9 blink frame 2 on", hist[(p + 1) % 16], 23'h7FFFFF);
      chk(hist[(p + 2) % 16] == '0, "R9 blink frame 3 off", hist[(p + 2) % 16], 0);
      chk(hist[(p + 3) % 16] == '0, "R9 blink frame 4 off", hist[(p + 3) % 16], 0);
      chk(hist[(p + 4) % 16] == '1, "R9 blink frame 5 on", hist[(p + 4) % 16], 23'h7FFFFF);
   endtask

   task automatic t_exit;
      logic [45:0] w;
      w = 46'h0F0F_3C3C_A5A5;
      test_n = 1'b1;
      dflt_mode = 1'b0;
      dim_val = 10'd300;
      disp_word = w;
      wait_frames(3);
      chk(len[0] == 300, "R9 normal duty after test", len[0], 300);
      chk(snap[0] == w[22:0], "R6 grid0 after test", snap[0], w[22:0]);
      chk(snap[1] == w[45:23], "R6 grid1 after test", snap[1], w[45:23]);
   endtask

   initial begin
      t_reset();
      t_frame();
      t_dim(1, 1, "R2 dimming 1");
      t_dim(300, 300, "R2 dimming 300");
      t_dim(1016, 1016, "R3 dimming 1016");
      t_dim(1023, 1016, "R3 dimming 1023 clamped");
      t_dark();
      t_content(46'h2AAA_AAAA_AAAA);
      t_content(46'h0000_0080_0001);
      t_boundary();
      t_default();
      t_test();
      t_exit();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule